// File: doc/BRIEF.md
# Random Byte Generator Peripheral

This peripheral sits on a 32-bit register bus and produces one random byte per generation interval. Software, or a hardware trigger line, starts generation. Once running, the block waits a fixed number of clock cycles and then does three things together. It latches a fresh byte into a readable value register, raises a sticky ready flag, and drives a one-cycle pulse on an event output that can be routed to other hardware. It then either starts the next interval straight away, or stops if the stop-after-ready shortcut is armed.

The interval is given in microseconds and turned into cycles by a clocks-per-microsecond parameter. It has two settings. The longer one is chosen when the bias-correction filter bit is set. Only the timing models the filter; no filtering is done. The bytes come from a 16-bit maximal-length LFSR that advances on every clock. A level interrupt is the AND of the interrupt enable and the ready flag. The enable can be written directly, or set and cleared through separate registers.

Top module: `rng_periph`

## Requirements
- R1: A write of exactly 1 to offset 0x000, or hw_start high at a clock edge, makes the block active and restarts the interval from its full length, even when an interval is already running. A write of any other value to 0x000 has no effect. The first ready pulse appears P+1 cycles after the edge that captured the start, where P is the interval in cycles.
- R2: A write of exactly 1 to offset 0x004, or hw_stop high at an edge, makes the block inactive and cancels the pending interval. Stop wins over a start in the same cycle. A write of any other value to 0x004 has no effect.
- R3: P is RAW_US*CLK_PER_US cycles when the filter bit (offset 0x504, bit 0) is 0, and FILT_US*CLK_PER_US cycles when it is 1. The bit's value just before the edge on which an interval starts sets that interval's length, so a change affects the next interval only.
- R4: When an interval expires, VALUE (offset 0x508, bits 7:0) takes the low byte of the LFSR and the ready flag is set. ready_pulse is high for exactly the one following cycle.
- R5: If the shortcut bit (offset 0x200, bit 0) was 1 when the interval expired, the block goes inactive. Otherwise the next interval starts on the same edge. Reads return the bit.
- R6: The ready flag is read at offset 0x100, bit 0. Writing 0 there clears it, and any nonzero write is ignored. An expiry in the same cycle as a clearing write leaves the flag set.
- R7: Interrupt enable: a write to 0x300 loads bit 0 of the data. Bit 0 set in a write to 0x304 sets the enable, and bit 0 set in a write to 0x308 clears it. Reading any of the three offsets returns the enable in bit 0.
- R8: irq is high exactly when the interrupt enable and the ready flag are both 1.
- R9: rst_n is asynchronous, active low, and its release is synchronised over two clocks. After reset the value, active state, ready flag, shortcut, enable and filter bits are all 0, and no interval runs.
- R10: Reads from any other offset, including misaligned ones, return 0, as do reads of 0x000 and 0x004. Writes to such offsets change nothing. bus_rdata is 0 when no read is selected.
- R11: The LFSR is a right-shifting Galois register. Each clock it shifts right by one, and if the bit shifted out was 1 it XORs the mask 0xB400. It holds LFSR_SEED (default 0xACE1) in reset and advances on every clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| hw_start | input | 1 | Hardware start trigger |
| hw_stop | input | 1 | Hardware stop trigger |
| ready_pulse | output | 1 | One-cycle pulse per new byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench aims at the edges where two events meet. These are a start landing mid-interval, which a design with a free-running counter would get wrong by firing early, and start and stop together, where the wrong priority keeps the block running. It also covers a clearing write on the expiry edge, which would lose an event if clear won. A filter change during an interval, applied at once instead of at the next reload, shows up as a wrong gap. Task writes with values other than 1, and writes to misaligned offsets, are also applied. A decoder that looks only at bit 0 or ignores the low address bits would trigger or corrupt state on them.

// File: rtl/rng_pkg.sv
`timescale 1ns/1ps
package rng_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int VAL_W  = 8;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_MASK = 16'hB400;

  localparam logic [ADDR_W-1:0] OFS_START  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_STOP   = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_EVRDY  = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_SHORT  = 12'h200;
  localparam logic [ADDR_W-1:0] OFS_IEN    = 12'h300;
  localparam logic [ADDR_W-1:0] OFS_IENSET = 12'h304;
  localparam logic [ADDR_W-1:0] OFS_IENCLR = 12'h308;
  localparam logic [ADDR_W-1:0] OFS_FILT   = 12'h504;
  localparam logic [ADDR_W-1:0] OFS_VALUE  = 12'h508;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_START,
    SEL_STOP,
    SEL_EVRDY,
    SEL_SHORT,
    SEL_IEN,
    SEL_IENSET,
    SEL_IENCLR,
    SEL_FILT,
    SEL_VALUE
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] ofs);
    reg_sel_e s;
    case (ofs)
      OFS_START:  s = SEL_START;
      OFS_STOP:   s = SEL_STOP;
      OFS_EVRDY:  s = SEL_EVRDY;
      OFS_SHORT:  s = SEL_SHORT;
      OFS_IEN:    s = SEL_IEN;
      OFS_IENSET: s = SEL_IENSET;
      OFS_IENCLR: s = SEL_IENCLR;
      OFS_FILT:   s = SEL_FILT;
      OFS_VALUE:  s = SEL_VALUE;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/rng_lfsr.sv
`timescale 1ns/1ps
module rng_lfsr #(
  parameter int                 W     = 16,
  parameter logic [W-1:0]       MASK  = 16'hB400,
  parameter logic [W-1:0]       SEED  = 16'hACE1,
  parameter int                 OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd_o
);

  // A zero seed would lock the register; substitute one.
  localparam logic [W-1:0] START_VAL = (SEED == '0) ? W'(1) : SEED;

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  always_comb begin
    state_d = {1'b0, state_q[W-1:1]};
    if (state_q[0]) begin
      state_d = state_d ^ MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= START_VAL;
    end else begin
      state_q <= state_d;
    end
  end

  generate
    if (OUT_W < W) begin : g_slice
      assign rnd_o = state_q[OUT_W-1:0];
    end else begin : g_full
      assign rnd_o = OUT_W'(state_q);
    end
  endgenerate

endmodule

// File: rtl/rng_run_ctrl.sv
`timescale 1ns/1ps
module rng_run_ctrl #(
  parameter int RAW_CYC  = 2672,
  parameter int FILT_CYC = 10560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic shortcut_i,
  input  logic filter_i,
  output logic active_o,
  output logic expire_o
);

  localparam int MAX_CYC = (FILT_CYC > RAW_CYC) ? FILT_CYC : RAW_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RAW_LOAD  = CNT_W'(RAW_CYC - 1);
  localparam logic [CNT_W-1:0] FILT_LOAD = CNT_W'(FILT_CYC - 1);

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] reload;
  logic             run_en;
  logic             expire;

  assign reload = filter_i ? FILT_LOAD : RAW_LOAD;
  assign run_en = start_i | stop_i | active_q;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    expire   = 1'b0;
    if (stop_i) begin
      active_d = 1'b0;
    end else if (start_i) begin
      active_d = 1'b1;
      cnt_d    = reload;
    end else if (active_q) begin
      if (cnt_q == '0) begin
        expire = 1'b1;
        if (shortcut_i) begin
          active_d = 1'b0;
        end else begin
          cnt_d = reload;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (run_en) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign active_o = active_q;
  assign expire_o = expire;

endmodule

// File: rtl/rng_regs.sv
`timescale 1ns/1ps
module rng_regs
  import rng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              expire_i,
  input  logic [VAL_W-1:0]  rnd_i,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              start_req_o,
  output logic              stop_req_o,
  output logic              short_o,
  output logic              filt_o,
  output logic              ien_o,
  output logic              flag_o
);

  reg_sel_e   sel_w;
  logic       wr_hit, rd_hit;
  logic       trig, zero, b0;

  logic             short_q, short_d, short_en;
  logic             filt_q,  filt_d,  filt_en;
  logic             ien_q,   ien_d,   ien_en;
  logic             flag_q,  flag_d,  flag_en;
  logic [VAL_W-1:0] value_q, value_d;
  logic             value_en;

  assign sel_w  = decode_ofs(bus_addr);
  assign wr_hit = bus_sel & bus_wr;
  assign rd_hit = bus_sel & ~bus_wr;
  assign trig   = (bus_wdata == DATA_W'(1));
  assign zero   = (bus_wdata == '0);
  assign b0     = bus_wdata[0];

  assign start_req_o = wr_hit && (sel_w == SEL_START) && trig;
  assign stop_req_o  = wr_hit && (sel_w == SEL_STOP)  && trig;

  always_comb begin
    short_en = wr_hit && (sel_w == SEL_SHORT);
    short_d  = b0;
    filt_en  = wr_hit && (sel_w == SEL_FILT);
    filt_d   = b0;

    ien_en = 1'b0;
    ien_d  = ien_q;
    if (wr_hit) begin
      case (sel_w)
        SEL_IEN: begin
          ien_en = 1'b1;
          ien_d  = b0;
        end
        SEL_IENSET: begin
          ien_en = b0;
          ien_d  = 1'b1;
        end
        SEL_IENCLR: begin
          ien_en = b0;
          ien_d  = 1'b0;
        end
        default: ;
      endcase
    end

    // A new value outranks a clearing write on the same edge.
    flag_en = 1'b0;
    flag_d  = flag_q;
    if (expire_i) begin
      flag_en = 1'b1;
      flag_d  = 1'b1;
    end else if (wr_hit && (sel_w == SEL_EVRDY) && zero) begin
      flag_en = 1'b1;
      flag_d  = 1'b0;
    end

    value_en = expire_i;
    value_d  = rnd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      short_q <= 1'b0;
      filt_q  <= 1'b0;
      ien_q   <= 1'b0;
      flag_q  <= 1'b0;
      value_q <= '0;
    end else begin
      if (short_en) short_q <= short_d;
      if (filt_en)  filt_q  <= filt_d;
      if (ien_en)   ien_q   <= ien_d;
      if (flag_en)  flag_q  <= flag_d;
      if (value_en) value_q <= value_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      case (sel_w)
        SEL_EVRDY:                      bus_rdata[0] = flag_q;
        SEL_SHORT:                      bus_rdata[0] = short_q;
        SEL_IEN, SEL_IENSET, SEL_IENCLR: bus_rdata[0] = ien_q;
        SEL_FILT:                       bus_rdata[0] = filt_q;
        SEL_VALUE:                      bus_rdata[VAL_W-1:0] = value_q;
        default: ;
      endcase
    end
  end

  assign short_o = short_q;
  assign filt_o  = filt_q;
  assign ien_o   = ien_q;
  assign flag_o  = flag_q;

endmodule

// File: rtl/rng_periph.sv
`timescale 1ns/1ps
module rng_periph
  import rng_pkg::*;
#(
  parameter int                  CLK_PER_US = 16,
  parameter int                  RAW_US     = 167,
  parameter int                  FILT_US    = 660,
  parameter logic [LFSR_W-1:0]   LFSR_SEED  = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              hw_start,
  input  logic              hw_stop,
  output logic              ready_pulse,
  output logic              irq
);

  localparam int RAW_CYC  = RAW_US  * CLK_PER_US;
  localparam int FILT_CYC = FILT_US * CLK_PER_US;

  // Reset: asserted asynchronously, released after two clocks.
  logic rst_s1_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  logic [VAL_W-1:0] rnd_byte;
  logic             start_req, stop_req;
  logic             start_any, stop_any;
  logic             short_q, filt_q, ien_q, flag_q;
  logic             run_active, expire;
  logic             pulse_q;

  rng_lfsr #(
    .W     (LFSR_W),
    .MASK  (LFSR_MASK),
    .SEED  (LFSR_SEED),
    .OUT_W (VAL_W)
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .rnd_o (rnd_byte)
  );

  rng_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .expire_i    (expire),
    .rnd_i       (rnd_byte),
    .bus_rdata   (bus_rdata),
    .start_req_o (start_req),
    .stop_req_o  (stop_req),
    .short_o     (short_q),
    .filt_o      (filt_q),
    .ien_o       (ien_q),
    .flag_o      (flag_q)
  );

  assign start_any = start_req | hw_start;
  assign stop_any  = stop_req  | hw_stop;

  rng_run_ctrl #(
    .RAW_CYC  (RAW_CYC),
    .FILT_CYC (FILT_CYC)
  ) u_run (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_any),
    .stop_i     (stop_any),
    .shortcut_i (short_q),
    .filter_i   (filt_q),
    .active_o   (run_active),
    .expire_o   (expire)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= expire;
    end
  end

  assign ready_pulse = pulse_q;
  assign irq         = ien_q & flag_q;

endmodule

// File: rtl/rng_periph_chk.sv
`timescale 1ns/1ps
module rng_periph_chk
  import rng_pkg::*;
(
  input logic              clk,
  input logic              rst_i_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              hw_start,
  input logic              hw_stop,
  input logic              ready_pulse,
  input logic              irq,
  input logic              run_active,
  input logic              short_q,
  input logic              ien_q,
  input logic              flag_q
);

  logic stop_wr, ienset_wr, unmapped_rd;

  assign stop_wr     = bus_sel && bus_wr && (bus_addr == OFS_STOP) && (bus_wdata == DATA_W'(1));
  assign ienset_wr   = bus_sel && bus_wr && (bus_addr == OFS_IENSET) && bus_wdata[0];
  assign unmapped_rd = bus_sel && !bus_wr && (decode_ofs(bus_addr) == SEL_NONE);

  // R1
  hw_start_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (hw_start && !hw_stop && !stop_wr) |=> run_active);

  // R2
  hw_stop_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    hw_stop |=> !run_active);

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    ready_pulse |=> !ready_pulse);

  // R5
  shortcut_halt_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    ready_pulse |-> (run_active != $past(short_q)));

  // R6
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    ready_pulse |-> flag_q);

  // R7
  ien_set_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    ienset_wr |=> ien_q);

  // R8
  pulse_irq_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ready_pulse && ien_q) |-> irq);

  // R8
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq |-> flag_q);

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    unmapped_rd |-> (bus_rdata == '0));

endmodule

bind rng_periph rng_periph_chk u_chk (
  .clk         (clk),
  .rst_i_n     (rst_sync_n),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .hw_start    (hw_start),
  .hw_stop     (hw_stop),
  .ready_pulse (ready_pulse),
  .irq         (irq),
  .run_active  (run_active),
  .short_q     (short_q),
  .ien_q       (ien_q),
  .flag_q      (flag_q)
);

// File: tb/rng_periph_test.sv
`timescale 1ns/1ps
module rng_periph_test;

  localparam int CPU   = 2;
  localparam int RAWU  = 3;
  localparam int FILTU = 7;
  localparam logic [15:0] SEED = 16'hACE1;
  localparam int P_RAW  = RAWU * CPU;
  localparam int P_FILT = FILTU * CPU;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hw_start = 1'b0, hw_stop = 1'b0;
  logic        ready_pulse, irq;

  always #2.5 clk = ~clk;

  rng_periph #(
    .CLK_PER_US (CPU),
    .RAW_US     (RAWU),
    .FILT_US    (FILTU),
    .LFSR_SEED  (SEED)
  ) uut (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .hw_start, .hw_stop, .ready_pulse, .irq
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // ---------------- behavioural reference ----------------
  bit          m_active, m_ev, m_ien, m_short, m_filt, m_pulse;
  int          m_rem, m_hold;
  logic [7:0]  m_val;
  logic [15:0] m_lfsr;

  function automatic int per(input bit f);
    return f ? P_FILT : P_RAW;
  endfunction

  task automatic model_reset();
    m_active = 0; m_ev = 0; m_ien = 0; m_short = 0; m_filt = 0; m_pulse = 0;
    m_rem = 0; m_val = '0; m_lfsr = SEED; m_hold = 0;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin : model
    logic [15:0] old;
    bit ws, st, sp, ex;
    if (!rst_n) begin
      model_reset();
    end else if (m_hold < 2) begin
      m_hold++;                       // R9 synchronised release
    end else begin
      old = m_lfsr;                   // R11
      m_lfsr = {1'b0, m_lfsr[15:1]} ^ (m_lfsr[0] ? 16'hB400 : 16'h0000);
      ws = bus_sel && bus_wr;
      st = (ws && bus_addr == 12'h000 && bus_wdata == 32'd1) || hw_start;
      sp = (ws && bus_addr == 12'h004 && bus_wdata == 32'd1) || hw_stop;
      ex = 0;
      if (sp) m_active = 0;
      else if (st) begin m_active = 1; m_rem = per(m_filt); end
      else if (m_active) begin
        m_rem--;
        if (m_rem == 0) begin
          ex = 1;
          if (m_short) m_active = 0; else m_rem = per(m_filt);
        end
      end
      if (ex) m_ev = 1;
      else if (ws && bus_addr == 12'h100 && bus_wdata == 0) m_ev = 0;
      if (ws) begin
        case (bus_addr)
          12'h200: m_short = bus_wdata[0];
          12'h504: m_filt  = bus_wdata[0];
          12'h300: m_ien   = bus_wdata[0];
          12'h304: if (bus_wdata[0]) m_ien = 1;
          12'h308: if (bus_wdata[0]) m_ien = 0;
          default: ;
        endcase
      end
      if (ex) m_val = old[7:0];
      m_pulse = ex;
    end
  end

  function automatic logic [31:0] exp_rd();
    if (!(bus_sel && !bus_wr)) return 32'd0;
    case (bus_addr)
      12'h100: return {31'd0, m_ev};
      12'h200: return {31'd0, m_short};
      12'h300, 12'h304, 12'h308: return {31'd0, m_ien};
      12'h504: return {31'd0, m_filt};
      12'h508: return {24'd0, m_val};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rd_tag();
    case (bus_addr)
      12'h100: return "R6";
      12'h200: return "R5";
      12'h300, 12'h304, 12'h308: return "R7";
      12'h504: return "R3";
      12'h508: return "R4 R11";
      default: return "R10";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk(rd_tag(), bus_rdata, exp_rd());
      chk("R8", {31'd0, irq}, {31'd0, m_ien & m_ev});
      chk("R4", {31'd0, ready_pulse}, {31'd0, m_pulse});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_fail++;
      $display("FAIL R1 watchdog: got %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drv(input bit s, input bit w, input logic [11:0] a,
                     input logic [31:0] d, input bit hs, input bit hp);
    @(posedge clk); #1;
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    hw_start = hs; hw_stop = hp;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    drv(1, 1, a, d, 0, 0);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    drv(1, 0, a, 0, 0, 0);
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) drv(0, 0, 12'h0, 0, 0, 0);
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      tick(1);
      n++;
    end while (!ready_pulse && n < 400);
  endtask

  task automatic count_pulses(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (ready_pulse) c++;
    end
  endtask

  logic [11:0] addrs [11] = '{12'h000, 12'h004, 12'h100, 12'h200, 12'h300,
                              12'h304, 12'h308, 12'h504, 12'h508, 12'h00C, 12'h102};

  initial begin
    logic [31:0] v;
    int n, c;

    tick(3);
    @(posedge clk); #1 rst_n = 1'b1;
    tick(4);

    // R9 reset state
    rd(12'h508, v); chk("R9", v, 0);
    rd(12'h100, v); chk("R9", v, 0);
    rd(12'h300, v); chk("R9", v, 0);
    rd(12'h200, v); chk("R9", v, 0);
    rd(12'h504, v); chk("R9", v, 0);
    count_pulses(20, c); chk("R9", c, 0);

    // R1 non-1 task values ignored; R2 likewise
    wr(12'h000, 32'd2); wr(12'h000, 32'd3); wr(12'h004, 32'd2);
    count_pulses(30, c); chk("R1", c, 0);

    // R1 R3 first interval
    wr(12'h000, 32'd1);
    wait_pulse(n); chk("R1 R3", n, P_RAW + 1);
    // R5 continuous without shortcut
    wait_pulse(n); chk("R5", n, P_RAW);

    // R2 register stop
    wr(12'h004, 32'd1);
    count_pulses(30, c); chk("R2", c, 0);

    // R7 R8 enable handling, flag is set
    wr(12'h304, 32'd1); tick(1); chk("R8", {31'd0, irq}, 1);
    wr(12'h308, 32'd2); rd(12'h300, v); chk("R7", v, 1);
    wr(12'h308, 32'd1); rd(12'h304, v); chk("R7", v, 0);
    wr(12'h300, 32'd3); rd(12'h308, v); chk("R7", v, 1);
    // R6 clear semantics
    wr(12'h100, 32'd4); rd(12'h100, v); chk("R6", v, 1);
    wr(12'h100, 32'd0); rd(12'h100, v); chk("R6", v, 0);
    chk("R8", {31'd0, irq}, 0);

    // R3 filtered interval, change takes effect at next reload
    wr(12'h504, 32'd1); wr(12'h000, 32'd1);
    wait_pulse(n); chk("R3", n, P_FILT + 1);
    wait_pulse(n); chk("R3", n, P_FILT);
    wr(12'h504, 32'd0);
    wait_pulse(n); chk("R3", n, P_FILT - 1);
    wait_pulse(n); chk("R3", n, P_RAW);

    // R5 shortcut
    wr(12'h200, 32'd1);
    wait_pulse(n);
    count_pulses(40, c); chk("R5", c, 0);
    rd(12'h200, v); chk("R5", v, 1);

    // R1 hardware start, R2 hardware stop
    drv(0, 0, 12'h0, 0, 1, 0);
    wait_pulse(n); chk("R1", n, P_RAW + 1);
    drv(0, 0, 12'h0, 0, 1, 0); tick(2); drv(0, 0, 12'h0, 0, 0, 1);
    count_pulses(30, c); chk("R2", c, 0);
    drv(0, 0, 12'h0, 0, 1, 1);
    count_pulses(30, c); chk("R2", c, 0);
    drv(1, 1, 12'h000, 32'd1, 0, 1);
    count_pulses(30, c); chk("R2", c, 0);

    // R1 restart mid-interval
    wr(12'h200, 32'd0); wr(12'h000, 32'd1); tick(3); wr(12'h000, 32'd1);
    wait_pulse(n); chk("R1", n, P_RAW + 1);
    wr(12'h004, 32'd1);

    // R10 unmapped and misaligned
    rd(12'h00C, v); chk("R10", v, 0);
    rd(12'h102, v); chk("R10", v, 0);
    rd(12'h000, v); chk("R10", v, 0);
    wr(12'h506, 32'd1); rd(12'h504, v); chk("R10", v, 0);
    wr(12'h002, 32'd1); count_pulses(20, c); chk("R10", c, 0);

    // mixed traffic, compared every cycle against the reference
    wr(12'h000, 32'd1);
    for (int i = 0; i < 1500; i++) begin
      drv($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
          addrs[$urandom_range(0, 10)], 32'($urandom_range(0, 3)),
          $urandom_range(0, 39) == 0, $urandom_range(0, 79) == 0);
    end
    tick(5);

    summary();
    $finish;
  end

endmodule